// File: doc/BRIEF.md
# Debug Memory Burst Engine

This engine sits between a word-oriented memory client and a lower engine that carries single debug-port or access-port register transactions. A client asks for a burst: a direction (load or store), an access-port number, a start address and a word count. The engine turns that into register traffic. It programs the access port's address register once with the start address. It then performs one access to the data register per word and relies on the target to step the address after each access.

Before every access-port access, the engine works out the bank-select value that access needs and compares it with a local copy of the last value it wrote. Only on a mismatch does it spend a transaction writing the select register. The copy changes only when that write is acknowledged as good. An invalidate input forces the copy to a value that can never match, so the next access always rewrites the select register.

Store data arrives through a valid/ready handshake. Load data leaves on a one-cycle strobe. Each burst ends with a one-cycle completion pulse that carries an error flag.

Top module: `dbg_mem_burst`

## Requirements
- R1: After reset `req_ready` is 1 and `txn_valid`, `done` and `rd_valid` are 0. A request is taken only while `req_ready` is 1, and `req_ready` stays 0 from the cycle after acceptance until the burst's `done` pulse.
- R2: The bank-select value is the access-port number placed at bits [31:24], OR'd with bits [7:4] of the target register offset. That field is 0 for both registers this engine uses. It is sent as a debug-port write (`txn_ap_sel`=0, `txn_rnw`=0, `txn_addr_bits`=2'b10) carrying that value in `txn_wdata`.
- R3: A select write is issued only when the needed value differs from the cached copy. The copy takes the new value only when that write completes with `txn_ok`=1. After a failed select write, the next burst to the same port writes the select register again.
- R4: The select check is made before the address-register access and again before every data-register access of the burst.
- R5: Each burst writes the address register exactly once, before any data access. This is an access-port write with `txn_addr_bits`=2'b01, and `txn_wdata` equals the start address.
- R6: Each word takes one access-port access with `txn_addr_bits`=2'b11: a read (`txn_rnw`=1) for loads and a write (`txn_rnw`=0) for stores. For loads, each returned word appears on `rd_data` with `rd_valid` high for one cycle, in address order.
- R7: For stores, each word is taken on a cycle where `wr_valid` and `wr_ready` are both 1. Words go to the target in the order accepted, and no data-register write is issued for a word before it has been taken.
- R8: A burst with a word count of zero still writes the address register, then completes without error and makes no data-register access.
- R9: A transaction that completes with `txn_ok`=0 ends the burst at once. The next cycle raises `done` with `done_err`=1, and no further transaction of that burst is issued.
- R10: While `cache_inval` is 1, the cached copy is all ones. With it held through a burst, every access-port access of the burst is preceded by a select write.
- R11: `done` is high for exactly one cycle per burst. While `txn_valid` is high and `txn_done` is low, `txn_valid` and all transaction fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_inval | input | 1 | Forces the select cache to all ones |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = store burst, 0 = load burst |
| req_ap | input | APW (8) | Access-port number |
| req_addr | input | AW (32) | Start address of the burst |
| req_count | input | CW (16) | Number of words |
| wr_valid | input | 1 | Store word present |
| wr_ready | output | 1 | Engine takes a store word this cycle if valid |
| wr_data | input | DW (32) | Store word |
| rd_valid | output | 1 | Load word strobe |
| rd_data | output | DW (32) | Load word |
| done | output | 1 | One-cycle burst completion pulse |
| done_err | output | 1 | Burst ended on a failed transaction (valid with done) |
| txn_valid | output | 1 | Register transaction requested, held until txn_done |
| txn_ap_sel | output | 1 | 1 = access-port register, 0 = debug-port register |
| txn_rnw | output | 1 | 1 = read, 0 = write |
| txn_addr_bits | output | 2 | Register address bits [3:2] |
| txn_wdata | output | DW (32) | Write data of the transaction |
| txn_done | input | 1 | Transaction complete (one cycle) |
| txn_ok | input | 1 | Transaction acknowledged without fault |
| txn_rdata | input | DW (32) | Read data of the transaction |

## Verification
The bench targets the select cache across bursts. A design that writes the select register on every access, or never, shows up as a wrong select-write count. A design that updates the cache before the acknowledge skips the rewrite after a faulted select write. Zero-word bursts catch an engine that touches the data register anyway or never completes. Faults placed on the address write and on a middle data access catch an engine that carries on after an error or reports it late. A held invalidate catches a cache that ignores it between words. Randomized stalls on both the target responses and the store-data supply catch words that are lost, duplicated or reordered.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_TAR,
        ST_WORD,
        ST_XFER,
        ST_FIN
    } eng_state_e;

    typedef enum logic {
        PH_TAR,
        PH_DATA
    } phase_e;

    // register offsets; bits [3:2] go on the wire, bits [7:4] form the bank
    localparam logic [7:0] REG_TAR    = 8'h04;
    localparam logic [7:0] REG_DATA   = 8'h0C;
    localparam logic [7:0] DP_SELECT  = 8'h08;
    localparam int         SEL_AP_LSB = 24;

endpackage

// File: rtl/dbg_sel_cache.sv
module dbg_sel_cache #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         invalidate,
    input  logic         commit,
    input  logic [W-1:0] probe,
    output logic         hit,
    output logic [W-1:0] cached
);

    logic [W-1:0] cache_d, cache_q;

    always_comb begin
        cache_d = cache_q;
        if (invalidate) begin
            cache_d = '1;
        end else if (commit) begin
            cache_d = probe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cache_q <= '1;
        end else begin
            cache_q <= cache_d;
        end
    end

    assign hit    = (probe == cache_q);
    assign cached = cache_q;

    // R10
    cache_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> (cached == '1));

    // R3
    cache_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !invalidate) |=> (cached == $past(probe)));

endmodule

// File: rtl/dbg_word_ctr.sv
module dbg_word_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
    assign last = (cnt_q == ONE);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);

endmodule

// File: rtl/dbg_mem_burst.sv
module dbg_mem_burst
    import dbg_mem_pkg::*;
#(
    parameter int APW = 8,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cache_inval,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [APW-1:0] req_ap,
    input  logic [AW-1:0]  req_addr,
    input  logic [CW-1:0]  req_count,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [DW-1:0]  wr_data,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic           done,
    output logic           done_err,
    output logic           txn_valid,
    output logic           txn_ap_sel,
    output logic           txn_rnw,
    output logic [1:0]     txn_addr_bits,
    output logic [DW-1:0]  txn_wdata,
    input  logic           txn_done,
    input  logic           txn_ok,
    input  logic [DW-1:0]  txn_rdata
);

    localparam int SEL_MSB = SEL_AP_LSB + APW - 1;

    typedef struct packed {
        eng_state_e     st;
        phase_e         ph;
        logic           write;
        logic [APW-1:0] ap;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wbuf;
        logic           err;
    } regs_t;

    regs_t r_d, r_q;

    logic [APW-1:0] probe_ap;
    logic [7:0]     probe_off;
    logic [DW-1:0]  probe_val;
    logic           sel_hit;
    logic [DW-1:0]  sel_cached;
    logic           sel_commit;
    logic           ctr_load, ctr_dec, ctr_zero, ctr_last;
    eng_state_e     data_next;

    // select value needed by the access about to be decided or issued
    always_comb begin
        probe_ap  = (r_q.st == ST_IDLE) ? req_ap : r_q.ap;
        probe_off = ((r_q.st == ST_IDLE) || (r_q.st == ST_SEL && r_q.ph == PH_TAR))
                    ? REG_TAR : REG_DATA;
        probe_val                      = '0;
        probe_val[SEL_MSB:SEL_AP_LSB]  = probe_ap;
        probe_val[7:0]                 = probe_off & 8'hF0;
    end

    dbg_sel_cache #(.W(DW)) i_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .invalidate (cache_inval),
        .commit     (sel_commit),
        .probe      (probe_val),
        .hit        (sel_hit),
        .cached     (sel_cached)
    );

    dbg_word_ctr #(.CW(CW)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (req_count),
        .dec      (ctr_dec),
        .zero     (ctr_zero),
        .last     (ctr_last)
    );

    assign rd_data = txn_rdata;

    always_comb begin
        r_d           = r_q;
        ctr_load      = 1'b0;
        ctr_dec       = 1'b0;
        sel_commit    = 1'b0;
        req_ready     = 1'b0;
        wr_ready      = 1'b0;
        rd_valid      = 1'b0;
        done          = 1'b0;
        done_err      = 1'b0;
        txn_valid     = 1'b0;
        txn_ap_sel    = 1'b0;
        txn_rnw       = 1'b0;
        txn_addr_bits = 2'b00;
        txn_wdata     = '0;
        data_next     = r_q.write ? ST_WORD : ST_XFER;

        case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.write = req_write;
                    r_d.ap    = req_ap;
                    r_d.addr  = req_addr;
                    r_d.err   = 1'b0;
                    ctr_load  = 1'b1;
                    if (sel_hit) begin
                        r_d.st = ST_TAR;
                    end else begin
                        r_d.st = ST_SEL;
                        r_d.ph = PH_TAR;
                    end
                end
            end
            ST_SEL: begin
                txn_valid     = 1'b1;
                txn_addr_bits = DP_SELECT[3:2];
                txn_wdata     = probe_val;
                if (txn_done) begin
                    if (txn_ok) begin
                        sel_commit = 1'b1;
                        r_d.st     = (r_q.ph == PH_TAR) ? ST_TAR : data_next;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FIN;
                    end
                end
            end
            ST_TAR: begin
                txn_valid     = 1'b1;
                txn_ap_sel    = 1'b1;
                txn_addr_bits = REG_TAR[3:2];
                txn_wdata     = DW'(r_q.addr);
                if (txn_done) begin
                    if (!txn_ok) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FIN;
                    end else if (ctr_zero) begin
                        r_d.st = ST_FIN;
                    end else if (sel_hit) begin
                        r_d.st = data_next;
                    end else begin
                        r_d.st = ST_SEL;
                        r_d.ph = PH_DATA;
                    end
                end
            end
            ST_WORD: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    r_d.wbuf = wr_data;
                    r_d.st   = ST_XFER;
                end
            end
            ST_XFER: begin
                txn_valid     = 1'b1;
                txn_ap_sel    = 1'b1;
                txn_rnw       = !r_q.write;
                txn_addr_bits = REG_DATA[3:2];
                txn_wdata     = r_q.write ? r_q.wbuf : '0;
                if (txn_done) begin
                    if (!txn_ok) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FIN;
                    end else begin
                        rd_valid = !r_q.write;
                        ctr_dec  = 1'b1;
                        if (ctr_last) begin
                            r_d.st = ST_FIN;
                        end else if (sel_hit) begin
                            r_d.st = data_next;
                        end else begin
                            r_d.st = ST_SEL;
                            r_d.ph = PH_DATA;
                        end
                    end
                end
            end
            ST_FIN: begin
                done     = 1'b1;
                done_err = r_q.err;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_TAR, write: 1'b0, ap: '0,
                     addr: '0, wbuf: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // R1
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    sel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ap_sel) |-> (txn_wdata != sel_cached));

    // R7
    wr_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !txn_valid);

    // R8
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_done && txn_ok && txn_ap_sel && txn_addr_bits == REG_TAR[3:2]
         && ctr_zero) |=> (done && !done_err));

    // R9
    fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_done && !txn_ok) |=> (done && done_err));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_done) |=> (txn_valid && $stable(txn_wdata) && $stable(txn_ap_sel)
                                      && $stable(txn_rnw) && $stable(txn_addr_bits)));

endmodule

// File: tb/test_dbg_mem_burst.sv
module test_dbg_mem_burst;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_inval = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_ap = '0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_count = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done, done_err;
    logic        txn_valid, txn_ap_sel, txn_rnw;
    logic [1:0]  txn_addr_bits;
    logic [31:0] txn_wdata;
    logic        txn_done = 1'b0;
    logic        txn_ok = 1'b0;
    logic [31:0] txn_rdata = '0;

    always #5 clk = ~clk;

    dbg_mem_burst i_dbg_mem_burst (.*);

    int checks = 0;
    int errors = 0;

    // target model
    logic [31:0] mem [64];
    logic [31:0] ref_mem [64];
    logic [31:0] tar = '0;
    logic [31:0] first_tar = '0;
    logic [31:0] last_sel = '0;
    int sel_cnt = 0, tar_cnt = 0, drw_cnt = 0, bad_cnt = 0;
    int txn_idx = 0, fault_idx = -1;
    bit armed = 0;
    int lat = 0;

    // store feed and load capture
    logic [31:0] wbuf [16];
    int wcnt = 0, widx = 0;
    bit hs_pending = 0;
    logic [31:0] rbuf [16];
    int rcount = 0;

    logic [31:0] exp_cache = 32'hFFFF_FFFF;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // responder
    initial begin
        forever begin
            @(negedge clk);
            #1;
            txn_done = 1'b0;
            txn_ok   = 1'b0;
            if (rst_n && txn_valid) begin
                if (!armed) begin
                    armed = 1;
                    lat   = int'($urandom % 3);
                end
                if (lat == 0) begin
                    armed = 0;
                    if (txn_idx == fault_idx) begin
                        txn_ok = 1'b0;
                    end else begin
                        txn_ok = 1'b1;
                        if (!txn_ap_sel) begin
                            if (txn_addr_bits == 2'b10 && !txn_rnw) begin
                                sel_cnt++;
                                last_sel = txn_wdata;
                            end else bad_cnt++;
                        end else if (txn_addr_bits == 2'b01 && !txn_rnw) begin
                            tar_cnt++;
                            tar = txn_wdata;
                            first_tar = txn_wdata;
                        end else if (txn_addr_bits == 2'b11) begin
                            if (tar_cnt == 0) bad_cnt++;
                            if (txn_rnw) txn_rdata = mem[tar[5:0]];
                            else mem[tar[5:0]] = txn_wdata;
                            tar = tar + 1;
                            drw_cnt++;
                        end else bad_cnt++;
                    end
                    txn_idx++;
                    txn_done = 1'b1;
                end else begin
                    lat--;
                end
            end
        end
    end

    // store-word feeder
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (hs_pending) widx++;
            wr_valid = (widx < wcnt) && ($urandom % 4 != 0);
            wr_data  = wbuf[widx % 16];
            #1;
            hs_pending = wr_valid && wr_ready;
        end
    end

    // load-word capture
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && rd_valid) begin
                if (rcount < 16) rbuf[rcount] = rd_data;
                rcount++;
            end
        end
    end

    task automatic run_burst(input bit wr, input logic [7:0] ap, input logic [31:0] addr,
                             input int cnt, input int fault_at, input bit inval_hold,
                             output bit err_seen);
        logic [31:0] sel_v;
        int exp_sels;
        int t;
        sel_v = {ap, 24'h0};
        exp_sels = inval_hold ? 1 + cnt : ((sel_v != exp_cache) ? 1 : 0);
        for (int i = 0; i < 16; i++) wbuf[i] = $urandom;
        sel_cnt = 0; tar_cnt = 0; drw_cnt = 0; bad_cnt = 0;
        txn_idx = 0; rcount = 0; widx = 0; hs_pending = 0;
        wcnt = wr ? cnt : 0;
        fault_idx = fault_at;
        @(negedge clk);
        cache_inval = inval_hold;
        req_write = wr; req_ap = ap; req_addr = addr; req_count = 16'(cnt);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        chk(req_ready == 1'b0, "R1 busy", {31'b0, req_ready}, 32'd0);
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            #2;
            t++;
        end
        chk(done == 1'b1, "R11 completion", {31'b0, done}, 32'd1);
        err_seen = done_err;
        @(negedge clk);
        #2;
        chk(done == 1'b0, "R11 single pulse", {31'b0, done}, 32'd0);
        cache_inval = 1'b0;
        if (fault_at < 0) begin
            chk(err_seen == 1'b0, "R9 no error", {31'b0, err_seen}, 32'd0);
            chk(sel_cnt == exp_sels, "R3 select writes", sel_cnt, exp_sels);
            if (exp_sels > 0) chk(last_sel == sel_v, "R2 select value", last_sel, sel_v);
            chk(bad_cnt == 0, "R2 transaction encoding", bad_cnt, 0);
            chk(tar_cnt == 1, "R5 address writes", tar_cnt, 1);
            chk(first_tar == addr, "R5 start address", first_tar, addr);
            chk(drw_cnt == cnt, "R6 data accesses", drw_cnt, cnt);
            if (wr) begin
                for (int i = 0; i < cnt; i++) begin
                    chk(mem[(addr + i) & 63] == wbuf[i], "R7 stored word",
                        mem[(addr + i) & 63], wbuf[i]);
                    ref_mem[(addr + i) & 63] = wbuf[i];
                end
            end else begin
                chk(rcount == cnt, "R6 load strobes", rcount, cnt);
                for (int i = 0; i < cnt && i < rcount; i++)
                    chk(rbuf[i] == ref_mem[(addr + i) & 63], "R6 loaded word",
                        rbuf[i], ref_mem[(addr + i) & 63]);
            end
            exp_cache = inval_hold ? 32'hFFFF_FFFF : sel_v;
        end
        fault_idx = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin
            mem[i] = $urandom;
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 reset ready", {31'b0, req_ready}, 32'd1);
        chk(txn_valid == 1'b0, "R1 reset txn", {31'b0, txn_valid}, 32'd0);
        chk(done == 1'b0 && rd_valid == 1'b0, "R1 reset done", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 zero-length burst
        run_burst(1'b0, 8'd1, 32'd10, 0, -1, 1'b0, e);
        chk(drw_cnt == 0, "R8 zero count", drw_cnt, 0);

        // R10 invalidate held: every access preceded by a select write
        run_burst(1'b1, 8'd5, 32'd20, 3, -1, 1'b1, e);
        // R10 cache left invalid: the next burst to the same port writes select again
        run_burst(1'b0, 8'd5, 32'd20, 1, -1, 1'b0, e);
        chk(sel_cnt == 1, "R10 after invalidate", sel_cnt, 1);
        // R4 same port again: cache hit on address and data accesses
        run_burst(1'b0, 8'd5, 32'd40, 2, -1, 1'b0, e);
        chk(sel_cnt == 0, "R4 cache hit", sel_cnt, 0);

        // R3 faulted select write leaves cache unchanged
        run_burst(1'b0, 8'd3, 32'd5, 2, 0, 1'b0, e);
        chk(e == 1'b1, "R9 select fault", {31'b0, e}, 32'd1);
        chk(tar_cnt == 0 && drw_cnt == 0, "R9 stop after select fault", tar_cnt + drw_cnt, 0);
        run_burst(1'b0, 8'd3, 32'd5, 2, -1, 1'b0, e);
        chk(sel_cnt == 1, "R3 rewrite after fault", sel_cnt, 1);

        // R9 fault on address write
        run_burst(1'b1, 8'd3, 32'd8, 2, 0, 1'b0, e);
        chk(e == 1'b1, "R9 address fault", {31'b0, e}, 32'd1);
        chk(drw_cnt == 0, "R9 no data after address fault", drw_cnt, 0);

        // R9 fault on third data access of a load
        run_burst(1'b0, 8'd3, 32'd30, 5, 3, 1'b0, e);
        chk(e == 1'b1, "R9 data fault", {31'b0, e}, 32'd1);
        chk(drw_cnt == 2, "R9 accesses before fault", drw_cnt, 2);
        chk(rcount == 2, "R9 strobes before fault", rcount, 2);

        // random bursts
        for (int n = 0; n < 40; n++) begin
            int cnt;
            cnt = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 6);
            run_burst(1'($urandom % 2), 8'($urandom % 3), 32'($urandom % 64), cnt, -1, 1'b0, e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule